// File: doc/BRIEF.md
# Byte Programming and Verify Sequencer for UV/OTP EPROMs

This block drives a byte-wide EPROM during programming. A host hands it one address/data pair at a time. For each byte it brings up the raised supply enables in a fixed order, sets up address and data, gives a single timed programming strobe, and then turns the part into read-back mode to compare the stored byte with the one intended. If the compare fails, it repeats the strobe until a retry budget runs out. It then lowers the supplies in reverse order and reports the result for that byte.

Every interval is a count of system clocks worked out from the clock-frequency parameter `CLK_MHZ`. Setup and hold intervals round up to whole clocks. The strobe length rounds to the nearest whole clock around the 100 µs nominal, so it lands well inside the 95–105 µs window at any practical clock rate. The block produces only the enables for the supply switches and never the analog levels. The host data driver is released before the read-back and is driven again only once the part has let go of the bus.

Byte input is a valid/ready stream. `in_ready` is high only while the sequencer is idle. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. While a byte is in progress, `in_valid` may stay high with any payload: nothing is taken and the pins in use do not change. A held request is accepted in the first idle cycle that follows.

Top module: `eprom_prog_seq`

## Requirements
- R1: `in_ready` is 1 exactly when no byte is in progress. A byte is taken only on a valid-and-ready edge. A request raised during a byte in progress is not taken, and `rom_addr` keeps the accepted address for as long as the VCC enable is on.
- R2: The VCC enable goes high at least SETUP_CYC = ceil(2 µs·f) clocks before the VPP enable, and goes low at least SETUP_CYC clocks after the VPP enable drops. The VPP enable is never on while the VCC enable is off.
- R3: Chip enable falls (active low) at least SETUP_CYC clocks after the VPP enable rises. Address and data are driven, with `rom_dout_en` = 1, at least SETUP_CYC clocks before every strobe. During the strobe they carry the accepted byte.
- R4: Each programming strobe holds `rom_pgm_n` = 0 for exactly PULSE_CYC = round(100 µs·f) clocks. During the strobe, `rom_ce_n` = 0, `rom_oe_n` = 1 and both supply enables are 1.
- R5: After the strobe ends, data stays driven for at least HOLD_CYC = SETUP_CYC clocks. `rom_dout_en` then drops at least one clock before `rom_oe_n` falls, and it is 0 whenever `rom_oe_n` = 0.
- R6: Read-back mode is `rom_ce_n` = 0, `rom_oe_n` = 0 and `rom_pgm_n` = 1 with both enables on. `rom_oe_n` stays low for VERIFY_CYC = ceil(100 ns·f)+1 clocks, and `rom_din` is compared on the last of them.
- R7: After `rom_oe_n` rises, `rom_dout_en` stays 0 for at least FLOAT_CYC = max(1, ceil(130 ns·f)) clocks.
- R8: On a compare mismatch, another strobe follows, up to MAX_TRIES strobes per byte in total. A match ends the byte with no further strobe.
- R9: Each byte ends with `done` high for exactly one clock. `done_pass` is 1 if and only if the last compare matched.
- R10: A failed byte sets `fail` and loads `fail_addr` with that byte's address. Both hold until the next byte is accepted, which clears `fail`.
- R11: After reset: `in_ready` = 1, `rom_ce_n` = `rom_oe_n` = `rom_pgm_n` = 1, and both enables, `rom_dout_en`, `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_MHZ |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte request valid |
| in_ready | output | 1 | Sequencer idle, can take a byte |
| in_addr | input | ADDR_W | Target address of the byte |
| in_data | input | DATA_W | Value to program |
| done | output | 1 | One-clock end-of-byte strobe |
| done_pass | output | 1 | Result of the byte, valid with done |
| fail | output | 1 | Sticky failure flag |
| fail_addr | output | ADDR_W | Address of the byte that failed |
| rom_addr | output | ADDR_W | Address bus to the memory |
| rom_dout | output | DATA_W | Data the host drives to the memory |
| rom_dout_en | output | 1 | Host data driver enable |
| rom_din | input | DATA_W | Data read back from the memory |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_pgm_n | output | 1 | Programming strobe, active low |
| vcc_hi_en | output | 1 | Raised VCC switch enable |
| vpp_hi_en | output | 1 | Programming-voltage switch enable |

## Verification
A state register that is wrong would show first as a broken mode combination on the control pins in the same clock. Examples are a strobe with output enable low, a read-back while the driver is on, or VPP without VCC. These are visible at the ports at once. A wrong interval counter shows as a strobe that is not exactly PULSE_CYC clocks long, or as a setup, hold or float gap that is too short. The bench measures these at the next edge of the pin that closes the interval. A wrong retry count or compare shows only at the end of the byte, as a strobe total or `done_pass` value that does not match what the memory model needed.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VCC_ON, ST_VPP_ON, ST_CE_SETUP, ST_PULSE, ST_HOLD,
    ST_TRISTATE, ST_VERIFY, ST_FLOAT, ST_VPP_OFF, ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic vcc_en;
    logic vpp_en;
    logic ce_n;
    logic oe_n;
    logic pgm_n;
    logic dout_en;
    logic done;
  } pin_ctl_t;

  // Interval in clocks, rounded up, at least one clock.
  function automatic int unsigned ns_to_cyc_up(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Interval in clocks, rounded to nearest, at least one clock.
  function automatic int unsigned ns_to_cyc_near(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 500) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Pin levels for each step of the sequence.
  function automatic pin_ctl_t decode_pins(seq_state_t s);
    pin_ctl_t p;
    p = '0;
    p.ce_n  = 1'b1;
    p.oe_n  = 1'b1;
    p.pgm_n = 1'b1;
    case (s)
      ST_VCC_ON:   begin p.vcc_en = 1'b1; p.dout_en = 1'b1; end
      ST_VPP_ON:   begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.dout_en = 1'b1; end
      ST_CE_SETUP: begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.dout_en = 1'b1; p.ce_n = 1'b0; end
      ST_PULSE:    begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.dout_en = 1'b1; p.ce_n = 1'b0;
                         p.pgm_n = 1'b0; end
      ST_HOLD:     begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.dout_en = 1'b1; p.ce_n = 1'b0; end
      ST_TRISTATE: begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.ce_n = 1'b0; end
      ST_VERIFY:   begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_FLOAT:    begin p.vcc_en = 1'b1; p.vpp_en = 1'b1; p.ce_n = 1'b0; end
      ST_VPP_OFF:  begin p.vcc_en = 1'b1; end
      ST_DONE:     begin p.done = 1'b1; end
      default:     ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int TW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4: interval counter steps down by one each clock until it empties
  a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eps_fsm.sv
module eps_fsm
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int MAX_TRIES  = 4,
  parameter int SETUP_CYC  = 250,
  parameter int PULSE_CYC  = 12500,
  parameter int HOLD_CYC   = 250,
  parameter int VERIFY_CYC = 14,
  parameter int FLOAT_CYC  = 17,
  parameter int TW         = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  input  logic              tmr_done,
  input  logic [DATA_W-1:0] rom_din,
  output pin_ctl_t          pins,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  seq_state_t        state_q, state_d;
  pin_ctl_t          pins_q;
  logic [TRY_W-1:0]  tries_q;
  logic              match_q, pass_q, fail_q;
  logic [ADDR_W-1:0] addr_q, fail_addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, give_up;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign give_up  = (tries_q >= TRY_W'(MAX_TRIES));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (in_valid) begin
        state_d = ST_VCC_ON; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
      end
      ST_VCC_ON: if (tmr_done) begin
        state_d = ST_VPP_ON; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
      end
      ST_VPP_ON: if (tmr_done) begin
        state_d = ST_CE_SETUP; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
      end
      ST_CE_SETUP: if (tmr_done) begin
        state_d = ST_PULSE; tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_done) begin
        state_d = ST_HOLD; tmr_load = 1'b1; tmr_val = TW'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_done) begin
        state_d = ST_TRISTATE; tmr_load = 1'b1; tmr_val = '0;
      end
      ST_TRISTATE: if (tmr_done) begin
        state_d = ST_VERIFY; tmr_load = 1'b1; tmr_val = TW'(VERIFY_CYC - 1);
      end
      ST_VERIFY: if (tmr_done) begin
        state_d = ST_FLOAT; tmr_load = 1'b1; tmr_val = TW'(FLOAT_CYC - 1);
      end
      ST_FLOAT: if (tmr_done) begin
        tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
        state_d  = (match_q || give_up) ? ST_VPP_OFF : ST_CE_SETUP;
      end
      ST_VPP_OFF: if (tmr_done) begin
        state_d = ST_DONE; tmr_load = 1'b1; tmr_val = '0;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pins_q      <= decode_pins(ST_IDLE);
      tries_q     <= '0;
      match_q     <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      pins_q  <= decode_pins(state_d);
      if (accept) begin
        addr_q  <= in_addr;
        data_q  <= in_data;
        tries_q <= '0;
        fail_q  <= 1'b0;
      end
      if (state_q == ST_CE_SETUP && tmr_done) tries_q <= tries_q + 1'b1;
      if (state_q == ST_VERIFY && tmr_done)   match_q <= (rom_din == data_q);
      if (state_q == ST_FLOAT && tmr_done && (match_q || give_up)) begin
        pass_q <= match_q;
        if (!match_q) begin
          fail_q      <= 1'b1;
          fail_addr_q <= addr_q;
        end
      end
    end
  end

  assign pins      = pins_q;
  assign addr      = addr_q;
  assign data      = data_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;

  // R2: VPP only comes up after VCC was already on, VCC only drops once VPP is off
  a_r2_vpp_after_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.vpp_en) |-> $past(pins_q.vcc_en));
  a_r2_vcc_after_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins_q.vcc_en) |-> !$past(pins_q.vpp_en));
  // R4: strobe only in program mode
  a_r4_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.pgm_n |-> (!pins_q.ce_n && pins_q.oe_n && pins_q.vpp_en && pins_q.vcc_en));
  // R5: the part never drives into the host driver
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.oe_n |-> !pins_q.dout_en);
  // R7: driver returns only after output enable has been high
  a_r7_float_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pins_q.dout_en) && pins_q.vpp_en) |-> $past(pins_q.oe_n));
  // R1: ready never while the supplies are up
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!pins_q.vcc_en && !pins_q.vpp_en));
  // R9: end-of-byte strobe lasts one clock
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.done |=> !pins_q.done);
  // R8: strobe count bounded by the retry budget
  a_r8_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(MAX_TRIES));

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int MAX_TRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic              done_pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rom_dout,
  output logic              rom_dout_en,
  input  logic [DATA_W-1:0] rom_din,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_pgm_n,
  output logic              vcc_hi_en,
  output logic              vpp_hi_en
);
  localparam int SETUP_CYC  = int'(ns_to_cyc_up(2000, CLK_MHZ));
  localparam int HOLD_CYC   = SETUP_CYC;
  localparam int PULSE_CYC  = int'(ns_to_cyc_near(100000, CLK_MHZ));
  localparam int VERIFY_CYC = int'(ns_to_cyc_up(100, CLK_MHZ)) + 1;
  localparam int FLOAT_CYC  = int'(ns_to_cyc_up(130, CLK_MHZ));
  localparam int TW         = $clog2(PULSE_CYC + 1);

  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  pin_ctl_t      pins;

  eps_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  eps_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_TRIES(MAX_TRIES),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .VERIFY_CYC(VERIFY_CYC), .FLOAT_CYC(FLOAT_CYC), .TW(TW)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_done(tmr_done),
    .rom_din(rom_din), .pins(pins), .addr(rom_addr), .data(rom_dout),
    .pass(done_pass), .fail(fail), .fail_addr(fail_addr)
  );

  assign done        = pins.done;
  assign rom_dout_en = pins.dout_en;
  assign rom_ce_n    = pins.ce_n;
  assign rom_oe_n    = pins.oe_n;
  assign rom_pgm_n   = pins.pgm_n;
  assign vcc_hi_en   = pins.vcc_en;
  assign vpp_hi_en   = pins.vpp_en;

endmodule

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
  localparam int CLK_MHZ = 4;
  localparam int AW = 14;
  localparam int DW = 8;
  localparam int MAXT = 3;
  localparam int SETUP = (2000 * CLK_MHZ + 999) / 1000;
  localparam int HOLD  = SETUP;
  localparam int PULSE = (100000 * CLK_MHZ + 500) / 1000;
  localparam int VER   = (100 * CLK_MHZ + 999) / 1000 + 1;
  localparam int FLOAT = (130 * CLK_MHZ + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, done, done_pass, fail, rom_dout_en, rom_ce_n, rom_oe_n, rom_pgm_n;
  logic vcc_hi_en, vpp_hi_en;
  logic [AW-1:0] fail_addr, rom_addr;
  logic [DW-1:0] rom_dout, rom_din;

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_data = '0;
  int k_need = 1, pulses_seen = 0;

  // Memory model: reads back the intended value once enough strobes were given
  assign rom_din = (!rom_ce_n && !rom_oe_n) ?
                   ((pulses_seen >= k_need) ? cur_data : (cur_data ^ 8'h5A)) : 8'hFF;

  eprom_prog_seq #(.CLK_MHZ(CLK_MHZ), .ADDR_W(AW), .DATA_W(DW), .MAX_TRIES(MAXT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .done(done), .done_pass(done_pass),
    .fail(fail), .fail_addr(fail_addr), .rom_addr(rom_addr), .rom_dout(rom_dout),
    .rom_dout_en(rom_dout_en), .rom_din(rom_din), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_pgm_n(rom_pgm_n), .vcc_hi_en(vcc_hi_en), .vpp_hi_en(vpp_hi_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_pass(input int k);
    return k <= MAXT;
  endfunction

  function automatic int exp_pulses(input int k);
    return (k <= MAXT) ? k : MAXT;
  endfunction

  // Pin monitor: intervals measured in clocks between edges
  int cyc = 0, t_vcc_on = 0, t_vpp_on = 0, t_ce = 0, t_dout_on = 0, t_pf = 0, t_pr = 0;
  int t_dout_off = 0, t_oe_f = 0, t_oe_r = 0, t_vpp_f = 0;
  bit seen_oe = 0;
  logic p_vcc = 0, p_vpp = 0, p_ce = 1, p_oe = 1, p_pgm = 1, p_dout = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (vcc_hi_en && !p_vcc) begin t_vcc_on = cyc; seen_oe = 0; end
      if (vpp_hi_en && !p_vpp) begin
        chk(cyc - t_vcc_on >= SETUP, "R2 vcc-to-vpp setup", cyc - t_vcc_on, SETUP);
        t_vpp_on = cyc;
      end
      if (!rom_ce_n && p_ce) begin
        t_ce = cyc;
        chk(cyc - t_vpp_on >= SETUP, "R3 vpp-to-ce setup", cyc - t_vpp_on, SETUP);
      end
      if (rom_dout_en && !p_dout) begin
        t_dout_on = cyc;
        if (seen_oe) chk(cyc - t_oe_r >= FLOAT, "R7 float gap", cyc - t_oe_r, FLOAT);
      end
      if (!rom_pgm_n && p_pgm) begin
        t_pf = cyc;
        chk(cyc - t_ce >= SETUP && cyc - t_dout_on >= SETUP, "R3 setup before strobe",
            cyc - t_dout_on, SETUP);
        chk(rom_addr == cur_addr && rom_dout == cur_data, "R3 bus during strobe",
            int'(rom_dout), int'(cur_data));
      end
      if (rom_pgm_n && !p_pgm) begin
        chk(cyc - t_pf == PULSE, "R4 strobe width", cyc - t_pf, PULSE);
        pulses_seen++;
        t_pr = cyc;
      end
      if (!rom_dout_en && p_dout) begin
        chk(cyc - t_pr >= HOLD, "R5 data hold", cyc - t_pr, HOLD);
        t_dout_off = cyc;
      end
      if (!rom_oe_n && p_oe) begin
        chk(!rom_dout_en && cyc > t_dout_off, "R5 release before read", cyc - t_dout_off, 1);
        seen_oe = 1;
        t_oe_f = cyc;
      end
      if (rom_oe_n && !p_oe) begin
        t_oe_r = cyc;
        chk(cyc - t_oe_f == VER, "R6 read window", cyc - t_oe_f, VER);
      end
      if (!vpp_hi_en && p_vpp) t_vpp_f = cyc;
      if (!vcc_hi_en && p_vcc)
        chk(cyc - t_vpp_f >= SETUP, "R2 vpp-off before vcc-off", cyc - t_vpp_f, SETUP);
      if (vpp_hi_en && !vcc_hi_en) chk(0, "R2 vpp without vcc", 1, 0);
      if (!rom_pgm_n && (rom_ce_n || !rom_oe_n || !vpp_hi_en))
        chk(0, "R4 program mode pins", 0, 1);
      if (!rom_oe_n && (rom_ce_n || !rom_pgm_n || !vpp_hi_en || rom_dout_en))
        chk(0, "R6 verify mode pins", 0, 1);
      if (vcc_hi_en && rom_addr != cur_addr)
        chk(0, "R1 address held while busy", int'(rom_addr), int'(cur_addr));
    end
    p_vcc = vcc_hi_en; p_vpp = vpp_hi_en; p_ce = rom_ce_n; p_oe = rom_oe_n;
    p_pgm = rom_pgm_n; p_dout = rom_dout_en;
  end

  task automatic run_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input int k);
    bit prev_fail;
    prev_fail = fail;
    cur_addr = a; cur_data = d; k_need = k; pulses_seen = 0;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1 ready drops after accept", int'(in_ready), 0);
    if (prev_fail) chk(fail == 1'b0, "R10 fail cleared by next byte", int'(fail), 0);
    repeat (20) @(negedge clk);
    in_valid = 1'b1; in_addr = ~a; in_data = ~d;
    chk(in_ready == 1'b0, "R1 busy refuses request", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(done_pass == exp_pass(k), "R9 pass result", int'(done_pass), int'(exp_pass(k)));
    chk(pulses_seen == exp_pulses(k), "R8 strobe count", pulses_seen, exp_pulses(k));
    chk(fail == !exp_pass(k), "R10 fail flag", int'(fail), int'(!exp_pass(k)));
    if (!exp_pass(k)) chk(fail_addr == a, "R10 fail address", int'(fail_addr), int'(a));
    @(negedge clk);
    chk(done == 1'b0, "R9 done one clock", int'(done), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    chk(0, "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(in_ready && rom_ce_n && rom_oe_n && rom_pgm_n, "R11 reset control pins", 0, 1);
    chk(!vcc_hi_en && !vpp_hi_en && !rom_dout_en && !done && !fail, "R11 reset enables", 1, 0);
    // directed corners
    run_byte(14'h0001, 8'hA5, 1);
    run_byte(14'h3FFF, 8'h3C, MAXT);
    run_byte(14'h1234, 8'h0F, MAXT + 1);
    repeat (10) @(negedge clk);
    chk(fail == 1'b1 && fail_addr == 14'h1234, "R10 fail holds while idle", int'(fail_addr), 'h1234);
    run_byte(14'h0100, 8'h80, 2);
    // random traffic
    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int k;
      a = AW'($urandom);
      d = DW'($urandom);
      k = 1 + int'($urandom % (MAXT + 1));
      run_byte(a, d, k);
    end
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule